// File: doc/BRIEF.md
# Runtime-Programmable Clock Divider

This block takes an input clock and produces a slower clock whose period is N input cycles. N comes from a 4-bit port and may be changed while the block runs. Odd and even values of N both give an output with a 50% duty cycle, measured in input half-periods.

A counter on the rising edge runs from 0 to N-1. It drives two toggle flops: one clocked on the rising edge and one on the falling edge. The output is the XOR of the two. For even N only the rising flop moves, and it toggles twice per count cycle. For odd N each flop toggles once per count cycle, and the falling flop toggles half an input cycle off the grid. This gives the odd factors their half-cycle placement.

The factor is captured only when the count wraps, so a period in progress always completes at the factor it started with. An active-high enable freezes the counter and both toggle flops. The output then holds its level.

Top module: `clk_div_prog`

## Requirements
- R1: While `rst_ni` is low, `clk_o` is low, and asserting `rst_ni` takes `clk_o` low at once, without waiting for a clock edge. After release, the first enabled rising edge starts a full period.
- R2: With `en_i` high and a steady factor N from 1 to 15, `clk_o` is periodic with a period of exactly N input cycles, which is 2N half-periods.
- R3: For even N, `clk_o` is high for N half-periods and low for N half-periods, and both of its transitions fall on rising input edges.
- R4: For odd N of 3 or more, `clk_o` is high for N half-periods and low for N half-periods. It rises on a rising input edge and falls on a falling input edge.
- R5: For N = 1, `clk_o` has the frequency of the input clock, with one half-period high and one half-period low.
- R6: A `ratio_i` value of 0 gives exactly the behaviour of a value of 1.
- R7: While `en_i` is low, the counter and both toggle flops keep their values, so `clk_o` stays constant. When `en_i` returns high, division resumes with the same N.
- R8: A new `ratio_i` value is taken only when the count wraps. The period already in progress, both its high and its low part, completes with the old factor. The new factor applies from the next period on.
- R9: Every output period begins with a rising edge of `clk_o` on a rising input edge, and `clk_o` is low just before each wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock; both edges are used |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable, active high; low freezes all state |
| ratio_i | input | RW (4) | Divide factor N; 0 behaves as 1 |
| clk_o | output | 1 | Divided clock |

## Verification
The bench sweeps every factor from 0 to 15 and measures run lengths in half-periods. A design with a wrong falling-edge target for odd factors would give unequal high and low times. A design with an off-by-one in the counter bound would give periods one cycle long or short. A factor of 1 is the corner where the falling flop must toggle every half-cycle; a divider that omitted this would give half the input frequency. The bench also freezes the block for each parity while the output is high or low. A divider that let the falling flop run on alone would invert its phase, and the loss of low-before-wrap alignment would be visible. Finally, the factor is changed from 15 to 2 in the middle of a high phase. A design that loaded the new factor at once would cut that phase short instead of finishing its 15 half-periods.

// File: rtl/clk_div_prog.sv
`timescale 1ns/1ps
module clk_div_prog #(
  parameter int RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [RW-1:0] ratio_i,
  output logic          clk_o
);

  logic [RW-1:0] cnt_q, cnt_d, n_q, n_d, n_req, half_d;
  logic          wrap, tr_hit, arm_d;
  logic          tr_q, tf_q, arm_q;

  assign n_req  = (ratio_i == '0) ? RW'(1) : ratio_i;
  assign wrap   = (cnt_q == n_q - RW'(1));
  assign cnt_d  = wrap ? '0 : cnt_q + RW'(1);
  assign n_d    = wrap ? n_req : n_q;
  // N/2 for even factors, (N-1)/2 for odd ones
  assign half_d = n_d >> 1;
  assign tr_hit = (cnt_d == '0) || (!n_d[0] && (cnt_d == half_d));
  assign arm_d  = en_i && n_d[0] && (cnt_d == half_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      n_q   <= RW'(1);
      tr_q  <= 1'b1;
      arm_q <= 1'b0;
    end else begin
      arm_q <= arm_d;
      if (en_i) begin
        cnt_q <= cnt_d;
        n_q   <= n_d;
        if (tr_hit) tr_q <= ~tr_q;
      end
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tf_q <= 1'b1;
    else if (arm_q) tf_q <= ~tf_q;
  end

  assign clk_o = tr_q ^ tf_q;

  // R2
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < n_q);

  // R6
  nonzero_ratio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_q != '0);

  // R8
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && wrap) |=> $stable(n_q));

  // R7
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q) && $stable(tr_q) && !arm_q);

  // R9
  wrap_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wrap) |-> !clk_o);

  // R4
  fall_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tf_q != $past(tf_q)) == arm_q);

endmodule

// File: tb/clk_div_prog_bench.sv
`timescale 1ns/1ps
module clk_div_prog_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] ratio = 4'd5;
  logic       clk_o;
  int checks = 0;
  int errs = 0;
  int runs [0:15];
  int runlvl [0:15];
  int runph [0:15];
  int nruns;

  always #2 clk = ~clk;

  clk_div_prog u_clk_div_prog (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ratio_i(ratio), .clk_o(clk_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // samples once per half-period, first sample just after a rising edge (phase 0)
  task automatic record(int halves);
    logic prev, v;
    int len, ph_start;
    @(posedge clk); #1;
    prev = clk_o; len = 1; ph_start = 0; nruns = 0;
    for (int h = 1; h < halves; h++) begin
      #2;
      v = clk_o;
      if (v == prev) len++;
      else begin
        if (nruns < 16) begin
          runs[nruns] = len; runlvl[nruns] = int'(prev); runph[nruns] = ph_start;
        end
        nruns++;
        prev = v; len = 1; ph_start = h % 2;
      end
    end
  endtask

  initial begin
    #800000;
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    int bad;
    logic ref_v, prev;
    en = 1'b1;
    // R1: low throughout reset
    repeat (3) @(posedge clk);
    bad = 0;
    for (int h = 0; h < 8; h++) begin #2; if (clk_o !== 1'b0) bad++; end
    chk("R1 low in reset", bad, 0);

    // R1 / R9: first edge after release starts a full period of 5
    @(negedge clk); #1; rst_n = 1'b1;
    record(40);
    chk("R9 first run high", runlvl[0], 1);
    chk("R1 first high run", runs[0], 5);
    chk("R1 first low run", runs[1], 5);

    // R1: asynchronous assertion while output high
    wait (clk_o == 1'b1);
    #1; rst_n = 1'b0; #0.5;
    chk("R1 async clear", int'(clk_o), 0);
    @(negedge clk); #1; rst_n = 1'b1;

    // R2..R6: sweep of all factors
    for (int r = 0; r < 16; r++) begin
      int n;
      string tag;
      n = (r == 0) ? 1 : r;
      tag = (r == 0) ? "R6" : (n == 1) ? "R5" : (n % 2 == 0) ? "R3" : "R4";
      @(negedge clk); ratio = 4'(r);
      repeat (40) @(posedge clk);
      record(2 * n * 6 + 4);
      chk({tag, " run count"}, int'(nruns >= 6), 1);
      for (int k = 1; k <= 4; k++) begin
        chk({tag, " run length"}, runs[k], n);
        if (runlvl[k] == 1) chk("R9 rise phase", runph[k], 0);
      end
      chk("R2 period halves", runs[1] + runs[2], 2 * n);
    end

    // R7: freeze and resume
    for (int j = 0; j < 3; j++) begin
      int n;
      n = (j == 0) ? 1 : (j == 1) ? 4 : 7;
      @(negedge clk); ratio = 4'(n);
      repeat (30) @(posedge clk);
      @(negedge clk); #1; en = 1'b0;
      ref_v = clk_o; bad = 0;
      for (int h = 0; h < 20; h++) begin #2; if (clk_o !== ref_v) bad++; end
      chk("R7 frozen output", bad, 0);
      @(negedge clk); #1; en = 1'b1;
      record(2 * n * 5 + 4);
      for (int k = 1; k <= 3; k++) chk("R7 resumed run", runs[k], n);
    end

    // R8: change 15 -> 2 mid high phase
    @(negedge clk); ratio = 4'd15;
    repeat (40) @(posedge clk);
    #1; prev = clk_o;
    forever begin
      @(posedge clk); #1;
      if (clk_o && !prev) break;
      prev = clk_o;
    end
    ratio = 4'd2;
    record(60);
    chk("R8 old high completes", runs[0], 13);
    chk("R8 old low completes", runs[1], 15);
    chk("R8 new high", runs[2], 2);
    chk("R8 new low", runs[3], 2);
    chk("R8 new high again", runs[4], 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule